// File: doc/BRIEF.md
# Display Power-State Transition Sequencer

This block walks a display panel controller between four power states: deep standby, sleep, full-resolution normal and quarter-resolution normal. A host pulses `startReq` with the wanted state on `targetState`. The sequencer then emits an ordered series of register-write commands to a downstream serial command transmitter over a valid/ready handshake. Each command has an opcode and zero, one or two data bytes. Millisecond pauses are timed from the `TICKS_PER_MS` parameter. The panel's long initialization table is not stored in the block. It is delegated to an external table player through a request/acknowledge pair, and the request carries a resolution select.

Transitions are never direct. Each request is broken into fixed sub-sequences: wake (standby to sleep), power-on (sleep to a normal state), power-off (normal to sleep) and shutdown (sleep to standby). A change of resolution always goes off, down to standby, back up to sleep and on again. Errors that the transmitter or the table player report are collected for the whole run. The reported state moves to the target only when the run was clean.

Top module: `panel_power_sequencer`

## Requirements
- R1: After reset `curState` is 0 (deep standby), and `busy`, `done`, `errFlag`, `cmdValid` and `initReq` are all low. State codes: 0 deep standby, 1 sleep, 2 full-resolution normal, 3 quarter-resolution normal.
- R2: The wake sub-sequence sends, in order:
  - three opcode-only commands with opcode 0x00 (`cmdLen`=0), with at least `TICKS_PER_MS` clock cycles between the acceptance of each one and the acceptance of the next command;
  - one-byte write 0x17 to opcode 0xB0.
- R3: The full-resolution power-on sub-sequence sends, in order:
  - 0x80 to 0xBC;
  - 0x00 to 0x3B;
  - 0x16 to 0xB0;
  - the two bytes 0xFF then 0xF9 to 0xB8 (`cmdData0` is sent first);
  - opcode-only 0x11.

  It then raises `initReq` with `initQuarter`=0 and holds both until `initAck`.
- R4: The quarter-resolution power-on sub-sequence is the same as in R3, with these differences: 0xBC receives 0x81, 0x3B receives 0x22, and the table request carries `initQuarter`=1.
- R5: The power-off sub-sequence sends, in order: opcode-only 0x28, the two bytes 0x80 then 0x02 to 0xB8, and opcode-only 0x10.
- R6: The shutdown sub-sequence sends one-byte 0x00 to 0xB0.
- R7: Requests that span more than one step chain the sub-sequences:
  - standby to either normal state runs wake then power-on;
  - either normal state to standby runs power-off then shutdown;
  - a change between the two normal states runs power-off, shutdown, wake and power-on, in that order.
- R8: A request for the current state pulses `done` on the cycle after the strobe, with `errFlag` low. It issues no command, no table request and never raises `busy`.
- R9: An error (`cmdErr` at a command acceptance, or `initErr` with `initAck`) does not stop the run. `errFlag` is high with `done`, and `curState` keeps its old value. In a clean run `curState` takes the target value, and it changes only together with `done`.
- R10: `busy` is high from the cycle after an accepted strobe until `done`. While `busy` is high, further strobes are ignored.
- R11: While `cmdValid` is high and `cmdReady` is low, the command fields stay stable. `cmdValid` and `initReq` are never high together.
- R12: `done` is a single-cycle pulse and is never high together with `busy`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startReq | input | 1 | Start strobe for a transition |
| targetState | input | 2 | Requested state code |
| cmdReady | input | 1 | Transmitter accepts the current command |
| cmdErr | input | 1 | Transmitter error, sampled at acceptance |
| initAck | input | 1 | Table player finished |
| initErr | input | 1 | Table player error, sampled with `initAck` |
| cmdValid | output | 1 | A command is offered |
| cmdOpcode | output | 8 | Command opcode |
| cmdLen | output | 2 | Number of data bytes (0 to 2) |
| cmdData0 | output | 8 | First data byte sent |
| cmdData1 | output | 8 | Second data byte sent |
| initReq | output | 1 | Request to run the initialization table |
| initQuarter | output | 1 | Table resolution: 1 quarter, 0 full |
| busy | output | 1 | A transition is running |
| done | output | 1 | One-cycle completion pulse |
| errFlag | output | 1 | Completion status, valid with `done` |
| curState | output | 2 | Current state code |

## Verification
An accepted strobe raises `busy` one cycle later, and a same-state request shows `done` one cycle later. The bench samples at the first falling edge after the sampling rising edge in both cases. The sequence length depends on handshake stalls and pauses, so the bench does not expect `done` at a fixed count. It waits for `done` at falling edges and then checks `errFlag` and `curState` at that edge and the pulse drop one edge later. Commands are logged at the falling edge before the rising edge that accepts them, together with the cycle number. The spacing after each 0x00 command is checked against `TICKS_PER_MS` from those logged cycles rather than from a fixed latency.

// File: rtl/pps_pkg.sv
package pps_pkg;

  typedef enum logic [1:0] {
    PWR_STANDBY = 2'd0,
    PWR_SLEEP   = 2'd1,
    PWR_FULL    = 2'd2,
    PWR_QUARTER = 2'd3
  } pwrState_t;

  typedef enum logic [2:0] {
    PH_NONE, PH_WAKE, PH_ON_FULL, PH_ON_QTR, PH_OFF, PH_STBY
  } phase_t;

  typedef enum logic [1:0] {
    SK_CMD, SK_WAIT, SK_INIT, SK_END
  } stepKind_t;

  localparam int STEP_W = 3;

  localparam logic [7:0] OP_NOP       = 8'h00;
  localparam logic [7:0] OP_SLP_ENTER = 8'h10;
  localparam logic [7:0] OP_SLP_EXIT  = 8'h11;
  localparam logic [7:0] OP_DISP_OFF  = 8'h28;
  localparam logic [7:0] OP_QUAD      = 8'h3B;
  localparam logic [7:0] OP_SUPPLY    = 8'hB0;
  localparam logic [7:0] OP_OUTCTL    = 8'hB8;
  localparam logic [7:0] OP_IFMODE    = 8'hBC;

  typedef struct packed {
    logic [7:0] opcode;
    logic [1:0] len;
    logic [7:0] d0;
    logic [7:0] d1;
  } cmdWord_t;

  typedef struct packed {
    stepKind_t kind;
    cmdWord_t  word;
  } step_t;

  typedef struct packed {
    logic seqBegin;
    logic seqEnd;
    logic loadCmd;
    logic startTimer;
    logic startInit;
  } ctrlStrobe_t;

  function automatic step_t mkStep(stepKind_t k, logic [7:0] op, logic [1:0] n,
                                   logic [7:0] a, logic [7:0] b);
    step_t s;
    s.kind        = k;
    s.word.opcode = op;
    s.word.len    = n;
    s.word.d0     = a;
    s.word.d1     = b;
    return s;
  endfunction

  // Fixed program of each sub-sequence, indexed by step number.
  function automatic step_t stepLookup(phase_t ph, logic [STEP_W-1:0] idx);
    step_t s;
    logic  q;
    q = (ph == PH_ON_QTR);
    s = mkStep(SK_END, 8'h00, 2'd0, 8'h00, 8'h00);
    case (ph)
      PH_WAKE: begin
        case (idx)
          3'd0, 3'd2, 3'd4: s = mkStep(SK_CMD, OP_NOP, 2'd0, 8'h00, 8'h00);
          3'd1, 3'd3, 3'd5: s = mkStep(SK_WAIT, 8'h00, 2'd0, 8'h00, 8'h00);
          3'd6:             s = mkStep(SK_CMD, OP_SUPPLY, 2'd1, 8'h17, 8'h00);
          default:          s = mkStep(SK_END, 8'h00, 2'd0, 8'h00, 8'h00);
        endcase
      end
      PH_ON_FULL, PH_ON_QTR: begin
        case (idx)
          3'd0: s = mkStep(SK_CMD, OP_IFMODE, 2'd1, q ? 8'h81 : 8'h80, 8'h00);
          3'd1: s = mkStep(SK_CMD, OP_QUAD, 2'd1, q ? 8'h22 : 8'h00, 8'h00);
          3'd2: s = mkStep(SK_CMD, OP_SUPPLY, 2'd1, 8'h16, 8'h00);
          3'd3: s = mkStep(SK_CMD, OP_OUTCTL, 2'd2, 8'hFF, 8'hF9);
          3'd4: s = mkStep(SK_CMD, OP_SLP_EXIT, 2'd0, 8'h00, 8'h00);
          3'd5: s = mkStep(SK_INIT, 8'h00, 2'd0, {7'd0, q}, 8'h00);
          default: s = mkStep(SK_END, 8'h00, 2'd0, 8'h00, 8'h00);
        endcase
      end
      PH_OFF: begin
        case (idx)
          3'd0: s = mkStep(SK_CMD, OP_DISP_OFF, 2'd0, 8'h00, 8'h00);
          3'd1: s = mkStep(SK_CMD, OP_OUTCTL, 2'd2, 8'h80, 8'h02);
          3'd2: s = mkStep(SK_CMD, OP_SLP_ENTER, 2'd0, 8'h00, 8'h00);
          default: s = mkStep(SK_END, 8'h00, 2'd0, 8'h00, 8'h00);
        endcase
      end
      PH_STBY: begin
        if (idx == 3'd0) s = mkStep(SK_CMD, OP_SUPPLY, 2'd1, 8'h00, 8'h00);
      end
      default: s = mkStep(SK_END, 8'h00, 2'd0, 8'h00, 8'h00);
    endcase
    return s;
  endfunction

  // Next sub-sequence from the walked position toward the goal.
  function automatic phase_t pickPhase(pwrState_t walk, pwrState_t goal, logic viaStby);
    phase_t p;
    if (walk == goal) p = PH_NONE;
    else begin
      case (walk)
        PWR_STANDBY: p = PH_WAKE;
        PWR_SLEEP: begin
          if (goal == PWR_STANDBY || viaStby) p = PH_STBY;
          else if (goal == PWR_FULL)          p = PH_ON_FULL;
          else                                p = PH_ON_QTR;
        end
        default: p = PH_OFF;
      endcase
    end
    return p;
  endfunction

  function automatic pwrState_t phaseEnd(phase_t ph);
    pwrState_t r;
    case (ph)
      PH_ON_FULL: r = PWR_FULL;
      PH_ON_QTR:  r = PWR_QUARTER;
      PH_STBY:    r = PWR_STANDBY;
      default:    r = PWR_SLEEP;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/pps_ctrl.sv
module pps_ctrl
  import pps_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        startReq,
  input  logic [1:0]  targetState,
  input  logic [1:0]  curState,
  input  logic        cmdAccept,
  input  logic        timerDone,
  input  logic        initDone,
  output ctrlStrobe_t strobe,
  output cmdWord_t    stepWord,
  output pwrState_t   goalState
);

  typedef enum logic [2:0] {
    C_IDLE, C_PLAN, C_ISSUE, C_WCMD, C_WTMR, C_WINIT
  } cstate_t;

  cstate_t             fsm;
  phase_t              phase;
  logic [STEP_W-1:0]   stepIdx;
  pwrState_t           walkState;
  logic                viaStby;
  step_t               curStep;
  phase_t              nextPh;
  logic                sameReq;

  assign curStep  = stepLookup(phase, stepIdx);
  assign stepWord = curStep.word;
  assign nextPh   = pickPhase(walkState, goalState, viaStby);
  assign sameReq  = (targetState == curState);

  always_comb begin
    strobe = '0;
    case (fsm)
      C_IDLE: begin
        if (startReq) begin
          if (sameReq) strobe.seqEnd   = 1'b1;
          else         strobe.seqBegin = 1'b1;
        end
      end
      C_PLAN: if (nextPh == PH_NONE) strobe.seqEnd = 1'b1;
      C_ISSUE: begin
        case (curStep.kind)
          SK_CMD:  strobe.loadCmd    = 1'b1;
          SK_WAIT: strobe.startTimer = 1'b1;
          SK_INIT: strobe.startInit  = 1'b1;
          default: ;
        endcase
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      fsm       <= C_IDLE;
      phase     <= PH_NONE;
      stepIdx   <= '0;
      walkState <= PWR_STANDBY;
      goalState <= PWR_STANDBY;
      viaStby   <= 1'b0;
    end else begin
      case (fsm)
        C_IDLE: begin
          if (startReq && !sameReq) begin
            goalState <= pwrState_t'(targetState);
            walkState <= pwrState_t'(curState);
            viaStby   <= curState[1] & targetState[1];
            fsm       <= C_PLAN;
          end
        end
        C_PLAN: begin
          if (nextPh == PH_NONE) fsm <= C_IDLE;
          else begin
            phase   <= nextPh;
            stepIdx <= '0;
            fsm     <= C_ISSUE;
          end
        end
        C_ISSUE: begin
          case (curStep.kind)
            SK_CMD:  fsm <= C_WCMD;
            SK_WAIT: fsm <= C_WTMR;
            SK_INIT: fsm <= C_WINIT;
            default: begin
              walkState <= phaseEnd(phase);
              if (phaseEnd(phase) == PWR_STANDBY) viaStby <= 1'b0;
              fsm <= C_PLAN;
            end
          endcase
        end
        C_WCMD: if (cmdAccept) begin
          stepIdx <= stepIdx + 1'b1;
          fsm     <= C_ISSUE;
        end
        C_WTMR: if (timerDone) begin
          stepIdx <= stepIdx + 1'b1;
          fsm     <= C_ISSUE;
        end
        C_WINIT: if (initDone) begin
          stepIdx <= stepIdx + 1'b1;
          fsm     <= C_ISSUE;
        end
        default: fsm <= C_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/pps_dp.sv
module pps_dp
  import pps_pkg::*;
#(
  parameter int unsigned TICKS_PER_MS = 125000
) (
  input  logic        clk,
  input  logic        rstN,
  input  ctrlStrobe_t strobe,
  input  cmdWord_t    stepWord,
  input  pwrState_t   goalState,
  input  logic        cmdReady,
  input  logic        cmdErr,
  input  logic        initAck,
  input  logic        initErr,
  output logic        cmdValid,
  output cmdWord_t    cmdOut,
  output logic        initReq,
  output logic        initQuarter,
  output logic        busy,
  output logic        done,
  output logic        errFlag,
  output logic [1:0]  curState,
  output logic        cmdAccept,
  output logic        timerDone,
  output logic        initDone
);

  localparam int CNT_W = $clog2(TICKS_PER_MS + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(TICKS_PER_MS - 1);

  logic [CNT_W-1:0] tmrCnt;
  logic             tmrRun;
  logic             errLatch;

  assign cmdAccept = cmdValid & cmdReady;
  assign initDone  = initReq & initAck;
  assign timerDone = tmrRun & (tmrCnt == '0);

  // Completion status and state register
  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy     <= 1'b0;
      done     <= 1'b0;
      errFlag  <= 1'b0;
      errLatch <= 1'b0;
      curState <= 2'd0;
    end else begin
      done <= strobe.seqEnd;
      if (strobe.seqBegin) begin
        busy     <= 1'b1;
        errLatch <= 1'b0;
      end else if ((cmdAccept && cmdErr) || (initDone && initErr)) begin
        errLatch <= 1'b1;
      end
      if (strobe.seqEnd) begin
        busy    <= 1'b0;
        errFlag <= busy & errLatch;
        if (busy && !errLatch) curState <= goalState;
      end
    end
  end

  // Command slot toward the transmitter
  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmdValid <= 1'b0;
      cmdOut   <= '0;
    end else begin
      if (cmdAccept) cmdValid <= 1'b0;
      if (strobe.loadCmd) begin
        cmdValid <= 1'b1;
        cmdOut   <= stepWord;
      end
    end
  end

  // Table player request
  always_ff @(posedge clk) begin
    if (!rstN) begin
      initReq     <= 1'b0;
      initQuarter <= 1'b0;
    end else begin
      if (initDone) initReq <= 1'b0;
      if (strobe.startInit) begin
        initReq     <= 1'b1;
        initQuarter <= stepWord.d0[0];
      end
    end
  end

  // Millisecond pause timer
  always_ff @(posedge clk) begin
    if (!rstN) begin
      tmrCnt <= '0;
      tmrRun <= 1'b0;
    end else if (strobe.startTimer) begin
      tmrCnt <= CNT_LOAD;
      tmrRun <= 1'b1;
    end else if (tmrRun) begin
      if (tmrCnt == '0) tmrRun <= 1'b0;
      else              tmrCnt <= tmrCnt - 1'b1;
    end
  end

endmodule

// File: rtl/panel_power_sequencer.sv
module panel_power_sequencer
  import pps_pkg::*;
#(
  parameter int unsigned TICKS_PER_MS = 125000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       startReq,
  input  logic [1:0] targetState,
  input  logic       cmdReady,
  input  logic       cmdErr,
  input  logic       initAck,
  input  logic       initErr,
  output logic       cmdValid,
  output logic [7:0] cmdOpcode,
  output logic [1:0] cmdLen,
  output logic [7:0] cmdData0,
  output logic [7:0] cmdData1,
  output logic       initReq,
  output logic       initQuarter,
  output logic       busy,
  output logic       done,
  output logic       errFlag,
  output logic [1:0] curState
);

  ctrlStrobe_t strobe;
  cmdWord_t    stepWord;
  cmdWord_t    cmdOut;
  pwrState_t   goalState;
  logic        cmdAccept;
  logic        timerDone;
  logic        initDone;

  pps_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .startReq   (startReq),
    .targetState(targetState),
    .curState   (curState),
    .cmdAccept  (cmdAccept),
    .timerDone  (timerDone),
    .initDone   (initDone),
    .strobe     (strobe),
    .stepWord   (stepWord),
    .goalState  (goalState)
  );

  pps_dp #(.TICKS_PER_MS(TICKS_PER_MS)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .stepWord   (stepWord),
    .goalState  (goalState),
    .cmdReady   (cmdReady),
    .cmdErr     (cmdErr),
    .initAck    (initAck),
    .initErr    (initErr),
    .cmdValid   (cmdValid),
    .cmdOut     (cmdOut),
    .initReq    (initReq),
    .initQuarter(initQuarter),
    .busy       (busy),
    .done       (done),
    .errFlag    (errFlag),
    .curState   (curState),
    .cmdAccept  (cmdAccept),
    .timerDone  (timerDone),
    .initDone   (initDone)
  );

  assign cmdOpcode = cmdOut.opcode;
  assign cmdLen    = cmdOut.len;
  assign cmdData0  = cmdOut.d0;
  assign cmdData1  = cmdOut.d1;

endmodule

// File: rtl/pps_checker.sv
module pps_checker (
  input logic       clk,
  input logic       rstN,
  input logic       cmdReady,
  input logic       initAck,
  input logic       cmdValid,
  input logic [7:0] cmdOpcode,
  input logic [1:0] cmdLen,
  input logic [7:0] cmdData0,
  input logic [7:0] cmdData1,
  input logic       initReq,
  input logic       initQuarter,
  input logic       busy,
  input logic       done,
  input logic [1:0] curState
);

  a_r11_hold_cmd: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && !cmdReady) |=> (cmdValid && $stable({cmdOpcode, cmdLen, cmdData0, cmdData1})));

  a_r11_one_outstanding: assert property (@(posedge clk) disable iff (!rstN)
    !(cmdValid && initReq));

  a_r3_init_hold: assert property (@(posedge clk) disable iff (!rstN)
    (initReq && !initAck) |=> (initReq && $stable(initQuarter)));

  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (!cmdValid && !initReq));

  a_r12_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  a_r12_done_not_busy: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

  a_r9_state_moves_with_done: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(curState) |-> done);

endmodule

bind panel_power_sequencer pps_checker u_pps_checker (
  .clk        (clk),
  .rstN       (rstN),
  .cmdReady   (cmdReady),
  .initAck    (initAck),
  .cmdValid   (cmdValid),
  .cmdOpcode  (cmdOpcode),
  .cmdLen     (cmdLen),
  .cmdData0   (cmdData0),
  .cmdData1   (cmdData1),
  .initReq    (initReq),
  .initQuarter(initQuarter),
  .busy       (busy),
  .done       (done),
  .curState   (curState)
);

// File: tb/test_panel_power_sequencer.sv
`timescale 1ns/1ps
module test_panel_power_sequencer;

  localparam int TICKS = 25;
  localparam int LOGN  = 512;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       startReq = 1'b0;
  logic [1:0] targetState = 2'd0;
  logic       cmdReady = 1'b0;
  logic       cmdErr = 1'b0;
  logic       initAck = 1'b0;
  logic       initErr = 1'b0;
  logic       cmdValid;
  logic [7:0] cmdOpcode;
  logic [1:0] cmdLen;
  logic [7:0] cmdData0;
  logic [7:0] cmdData1;
  logic       initReq;
  logic       initQuarter;
  logic       busy;
  logic       done;
  logic       errFlag;
  logic [1:0] curState;

  int testsRun = 0;
  int testsFail = 0;
  int cyc = 0;
  int readyMode = 0;
  int errAt = -1;
  bit initErrInj = 1'b0;
  int initWait = 0;

  logic [7:0] gotOp [LOGN];
  int         gotLen[LOGN];
  logic [7:0] gotD0 [LOGN];
  logic [7:0] gotD1 [LOGN];
  int         gotCyc[LOGN];
  int         gotN = 0;

  logic [7:0] expOp [64];
  int         expLen[64];
  logic [7:0] expD0 [64];
  logic [7:0] expD1 [64];
  int         expN = 0;

  always #4 clk = ~clk;

  panel_power_sequencer #(.TICKS_PER_MS(TICKS)) i_panel_power_sequencer (
    .clk(clk), .rstN(rstN), .startReq(startReq), .targetState(targetState),
    .cmdReady(cmdReady), .cmdErr(cmdErr), .initAck(initAck), .initErr(initErr),
    .cmdValid(cmdValid), .cmdOpcode(cmdOpcode), .cmdLen(cmdLen),
    .cmdData0(cmdData0), .cmdData1(cmdData1), .initReq(initReq),
    .initQuarter(initQuarter), .busy(busy), .done(done), .errFlag(errFlag),
    .curState(curState)
  );

  // Transmitter and table-player models, driven and sampled at falling edges
  always @(negedge clk) begin
    cyc = cyc + 1;
    cmdReady = (readyMode == 0) ? 1'b1 : ((cyc % 3) == 0);
    cmdErr   = (gotN == errAt);
    if (cmdValid && cmdReady && gotN < LOGN) begin
      gotOp[gotN] = cmdOpcode; gotLen[gotN] = int'(cmdLen);
      gotD0[gotN] = cmdData0;  gotD1[gotN] = cmdData1;
      gotCyc[gotN] = cyc;      gotN = gotN + 1;
    end
    if (initReq && !initAck) begin
      initWait = initWait + 1;
      if (initWait >= 3 && gotN < LOGN) begin
        initAck = 1'b1; initErr = initErrInj; initWait = 0;
        gotOp[gotN] = 8'h00; gotLen[gotN] = 3;
        gotD0[gotN] = {7'd0, initQuarter}; gotD1[gotN] = 8'h00;
        gotCyc[gotN] = cyc; gotN = gotN + 1;
      end
    end else begin
      initAck = 1'b0; initErr = 1'b0;
    end
    if (cyc > 150000) begin
      testsFail = testsFail + 1;
      $display("FAIL watchdog: run did not finish");
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFail);
      $finish;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    testsRun = testsRun + 1;
    if (!ok) begin
      testsFail = testsFail + 1;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic push(input logic [7:0] op, input int n, input logic [7:0] a, input logic [7:0] b);
    expOp[expN] = op; expLen[expN] = n; expD0[expN] = a; expD1[expN] = b;
    expN = expN + 1;
  endtask

  task automatic expWake();   // R2
    push(8'h00, 0, 0, 0); push(8'h00, 0, 0, 0); push(8'h00, 0, 0, 0);
    push(8'hB0, 1, 8'h17, 0);
  endtask
  task automatic expOn(input bit q);   // R3 / R4
    push(8'hBC, 1, q ? 8'h81 : 8'h80, 0);
    push(8'h3B, 1, q ? 8'h22 : 8'h00, 0);
    push(8'hB0, 1, 8'h16, 0);
    push(8'hB8, 2, 8'hFF, 8'hF9);
    push(8'h11, 0, 0, 0);
    push(8'h00, 3, {7'd0, q}, 0);
  endtask
  task automatic expOff();   // R5
    push(8'h28, 0, 0, 0); push(8'hB8, 2, 8'h80, 8'h02); push(8'h10, 0, 0, 0);
  endtask
  task automatic expStby();   // R6
    push(8'hB0, 1, 8'h00, 0);
  endtask

  task automatic compareLog(input int base, input string tag);
    check(gotN - base == expN, {tag, " entry count"}, gotN - base, expN);
    for (int i = 0; i < expN && base + i < gotN; i++) begin
      check(gotOp[base+i] == expOp[i], {tag, " opcode"}, gotOp[base+i], expOp[i]);
      check(gotLen[base+i] == expLen[i], {tag, " length"}, gotLen[base+i], expLen[i]);
      if (expLen[i] >= 1)
        check(gotD0[base+i] == expD0[i], {tag, " first byte"}, gotD0[base+i], expD0[i]);
      if (expLen[i] == 2)
        check(gotD1[base+i] == expD1[i], {tag, " second byte"}, gotD1[base+i], expD1[i]);
      if (expOp[i] == 8'h00 && expLen[i] == 0 && base + i + 1 < gotN)
        check(gotCyc[base+i+1] - gotCyc[base+i] >= TICKS, "R2 pause after 0x00",
              gotCyc[base+i+1] - gotCyc[base+i], TICKS);
    end
  endtask

  task automatic waitDone(input string tag);
    int n = 0;
    while (!done && n < 20000) begin
      @(negedge clk);
      n++;
    end
    check(done == 1'b1, {tag, " done seen"}, done, 1);
  endtask

  // Generic transition run: strobe, wait, compare results and log.
  task automatic runSeq(input int tgt, input bit expErr, input int expState, input string tag);
    int base = gotN;
    @(negedge clk);
    startReq = 1'b1; targetState = 2'(tgt);
    @(negedge clk);
    startReq = 1'b0;
    check(busy == 1'b1, "R10 busy after strobe", busy, 1);
    waitDone(tag);
    check(errFlag == expErr, "R9 error flag with done", errFlag, expErr);
    check(curState == 2'(expState), "R9 state after run", curState, expState);
    check(busy == 1'b0, "R12 busy low with done", busy, 0);
    @(negedge clk);
    check(done == 1'b0, "R12 done single pulse", done, 0);
    compareLog(base, tag);
  endtask

  task automatic t_reset();
    check(curState == 2'd0, "R1 reset state", curState, 0);
    check(busy == 1'b0, "R1 busy low", busy, 0);
    check(done == 1'b0, "R1 done low", done, 0);
    check(errFlag == 1'b0, "R1 error low", errFlag, 0);
    check(cmdValid == 1'b0 && initReq == 1'b0, "R1 no request", {cmdValid, initReq}, 0);
  endtask

  task automatic t_same(input int st);
    int base = gotN;
    @(negedge clk);
    startReq = 1'b1; targetState = 2'(st);
    @(negedge clk);
    startReq = 1'b0;
    check(done == 1'b1, "R8 done next cycle", done, 1);
    check(busy == 1'b0, "R8 no busy", busy, 0);
    check(errFlag == 1'b0, "R8 success", errFlag, 0);
    repeat (5) @(negedge clk);
    check(gotN == base, "R8 no writes", gotN - base, 0);
    check(curState == 2'(st), "R8 state kept", curState, st);
  endtask

  task automatic t_busy_ignore();
    int base = gotN;
    expN = 0; expWake(); expOn(1'b0);
    @(negedge clk);
    startReq = 1'b1; targetState = 2'd2;
    @(negedge clk);
    startReq = 1'b0;
    repeat (10) @(negedge clk);
    startReq = 1'b1; targetState = 2'd0;
    @(negedge clk);
    startReq = 1'b0;
    check(busy == 1'b1, "R10 still busy after ignored strobe", busy, 1);
    waitDone("R10 ignored strobe");
    check(curState == 2'd2, "R10 first target kept", curState, 2);
    @(negedge clk);
    compareLog(base, "R10 ignored strobe");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();

    expN = 0; expWake();
    runSeq(1, 1'b0, 1, "R2 standby to sleep");

    t_same(1);

    readyMode = 1;
    expN = 0; expOn(1'b0);
    runSeq(2, 1'b0, 2, "R3 sleep to full");

    expN = 0; expOff(); expStby(); expWake(); expOn(1'b1);
    runSeq(3, 1'b0, 3, "R7 full to quarter");

    readyMode = 0;
    expN = 0; expOff(); expStby();
    runSeq(0, 1'b0, 0, "R7 quarter to standby");

    errAt = gotN + 5;
    expN = 0; expWake(); expOn(1'b0);
    runSeq(2, 1'b1, 0, "R9 command error");
    errAt = -1;

    initErrInj = 1'b1;
    expN = 0; expWake(); expOn(1'b1);
    runSeq(3, 1'b1, 0, "R4 init error");
    initErrInj = 1'b0;

    t_same(0);

    t_busy_ignore();

    expN = 0; expOff();
    runSeq(1, 1'b0, 1, "R5 full to sleep");

    expN = 0; expStby();
    runSeq(0, 1'b0, 0, "R6 sleep to standby");

    $display("[TB] %0d tests run, %0d failed", testsRun, testsFail);
    $finish;
  end

endmodule